// File: doc/BRIEF.md
# Latched Gate-Enable Safety Interlock

This block drives the enable pin of a three-phase gate driver and removes it as soon as a hardware fault appears. Two fault lines, the active-low emergency stop and the overcurrent comparator, gate the enable through pure combinational logic. The enable therefore falls in the same instant as the fault and does not wait for a clock edge. All five fault sources (emergency stop, overcurrent, bus overvoltage, bus undervoltage, stall) also pass through synchronisers into a small state machine. That machine latches the shutdown and records which fault came first. When the fault is removed the bridge stays off and the motor coasts.

Firmware restarts the drive with a one-cycle clear request. The state machine honours that request only when every synchronised fault line is quiet. While any cause persists, the request is dropped. After reset the block starts in a safe state with the gates off, and firmware must issue one clear to arm it.

The states are `ST_SAFE` (after reset, nothing recorded, gates off), `ST_ARMED` (gates may be on), `ST_TRIPPED` (fault recorded, a cause still present) and `ST_HOLD` (fault recorded, causes gone, waiting for clear). The transitions are:

- SAFE to ARMED on a clear with no fault.
- SAFE to TRIPPED on any fault.
- ARMED to TRIPPED on any fault, which records the code.
- TRIPPED to HOLD when all causes are gone.
- HOLD to TRIPPED if a cause returns.
- HOLD to ARMED on a clear, which wipes the code.

Top module: `gate_interlock`

## Requirements
- R1: After reset `gate_en`=0, `fault_code`=0 and `fault_latched`=0, and the block stays disarmed until a clear request is given with no fault active.
- R2: While `estop_n` is low, `gate_en` is 0 in the same instant, with no clock edge needed. A broken wire reads low and therefore stops the drive.
- R3: While `oc_trip` is high, `gate_en` is 0 in the same instant, with no clock edge needed.
- R4: A fault on any source held for SYNC_STAGES+1 clock edges sets `fault_latched`=1 and keeps `gate_en`=0. Both stay that way after the cause is removed.
- R5: The fault code values are 0 none, 1 emergency stop, 2 overcurrent, 3 overvoltage, 4 undervoltage, 5 stall.
- R6: Faults that first appear in the same cycle are resolved by priority: emergency stop, then overcurrent, then overvoltage, then undervoltage, then stall.
- R7: Once a code is recorded, later faults do not change it until a clear is accepted.
- R8: A clear request is ignored while any synchronised fault is still asserted.
- R9: A clear request with all faults gone is applied at the next clock edge. After that edge `fault_code`=0 and `fault_latched`=0, and `gate_en`=1 if the raw lines are quiet.
- R10: A fault that appears while the block is still disarmed after reset is latched and coded in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| estop_n | input | 1 | Emergency stop, low means stop |
| oc_trip | input | 1 | Overcurrent comparator output, high means trip |
| ov_flag | input | 1 | Bus overvoltage indication |
| uv_flag | input | 1 | Bus undervoltage indication |
| stall_flag | input | 1 | Stall fault indication |
| clr_req | input | 1 | Firmware request to re-arm, one cycle |
| gate_en | output | 1 | Gate-driver enable |
| fault_code | output | 3 | First recorded fault code |
| fault_latched | output | 1 | A fault is latched |

## Verification
The assertions check the following on every cycle:

- The combinational cut from both raw fault lines.
- A latched fault never leaves the enable on or the code at zero.
- The code never moves while it is latched.
- The machine enters the armed state only on a clear, and never straight from TRIPPED.

Only the bench scenarios can show that the correct code comes out for every combination of simultaneous faults. The same holds for first-fault retention when faults arrive in sequence, and for the full recovery after the causes are removed.

// File: rtl/gi_pkg.sv
package gi_pkg;
    localparam int FAULT_W = 5;
    localparam int CODE_W  = 3;

    typedef enum logic [1:0] {
        ST_SAFE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_TRIPPED = 2'd2,
        ST_HOLD    = 2'd3
    } gi_state_t;

    typedef enum logic [CODE_W-1:0] {
        FC_NONE      = 3'd0,
        FC_ESTOP     = 3'd1,
        FC_OVERCUR   = 3'd2,
        FC_OVERVOLT  = 3'd3,
        FC_UNDERVOLT = 3'd4,
        FC_STALL     = 3'd5
    } fault_code_t;
endpackage

// File: rtl/gi_sync.sv
module gi_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gi_fault_prio.sv
module gi_fault_prio #(
    parameter int N  = 5,
    parameter int CW = 3
) (
    input  logic [N-1:0]  act,
    output logic          any_o,
    output logic [CW-1:0] code_o
);
    // bit 0 carries the highest priority; code = index + 1
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act[i]) code_o = CW'(i + 1);
        end
    end

    assign any_o = |act;
endmodule

// File: rtl/gi_fsm.sv
module gi_fsm
    import gi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_any,
    input  logic [CODE_W-1:0] flt_code,
    input  logic              clr_req,
    output logic              armed_o,
    output logic              latched_o,
    output logic [CODE_W-1:0] code_o
);
    gi_state_t         state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_SAFE: begin
                if (flt_any) begin
                    state_d = ST_TRIPPED;
                    code_d  = flt_code;
                end else if (clr_req) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (flt_any) begin
                    state_d = ST_TRIPPED;
                    code_d  = flt_code;
                end
            end
            ST_TRIPPED: begin
                if (!flt_any) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (flt_any) begin
                    state_d = ST_TRIPPED;
                end else if (clr_req) begin
                    state_d = ST_ARMED;
                    code_d  = '0;
                end
            end
            default: state_d = ST_SAFE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAFE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    always_comb begin
        armed_o   = 1'b0;
        latched_o = 1'b0;
        unique case (state_q)
            ST_SAFE:    ;
            ST_ARMED:   armed_o   = 1'b1;
            ST_TRIPPED: latched_o = 1'b1;
            ST_HOLD:    latched_o = 1'b1;
            default:    ;
        endcase
    end
    assign code_o = code_q;

    // R8: no clear accepted while a cause is present
    p_no_clear_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIPPED) |=> (state_q != ST_ARMED));
    // R7: recorded code holds while latched
    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_o && $past(latched_o)) |-> (code_o == $past(code_o)));
    // R9: arming only follows a clear request
    p_arm_on_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && $past(state_q) != ST_ARMED) |-> $past(clr_req));
endmodule

// File: rtl/gate_interlock.sv
module gate_interlock
    import gi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              estop_n,
    input  logic              oc_trip,
    input  logic              ov_flag,
    input  logic              uv_flag,
    input  logic              stall_flag,
    input  logic              clr_req,
    output logic              gate_en,
    output logic [CODE_W-1:0] fault_code,
    output logic              fault_latched
);
    logic [FAULT_W-1:0] raw_flt, syn_flt;
    logic               flt_any, armed;
    logic [CODE_W-1:0]  flt_code;

    // priority order: index 0 first
    assign raw_flt = {stall_flag, uv_flag, ov_flag, oc_trip, ~estop_n};

    gi_sync #(.W(FAULT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_flt), .q(syn_flt)
    );

    gi_fault_prio #(.N(FAULT_W), .CW(CODE_W)) u_prio (
        .act(syn_flt), .any_o(flt_any), .code_o(flt_code)
    );

    gi_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .flt_any(flt_any), .flt_code(flt_code),
        .clr_req(clr_req), .armed_o(armed), .latched_o(fault_latched),
        .code_o(fault_code)
    );

    // raw lines cut the enable without any register in the path
    assign gate_en = armed & estop_n & ~oc_trip;

    p_estop_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !estop_n |-> !gate_en);
    p_oc_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> !gate_en);
    p_latched_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> (!gate_en && fault_code != '0));
endmodule

// File: tb/gate_interlock_bench.sv
module gate_interlock_bench;
    localparam int SYNC_STAGES = 2;
    localparam int SETTLE      = SYNC_STAGES + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic estop_n = 1'b1, oc_trip = 1'b0, ov_flag = 1'b0, uv_flag = 1'b0, stall_flag = 1'b0;
    logic clr_req = 1'b0;
    logic gate_en, fault_latched;
    logic [2:0] fault_code;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gate_interlock #(.SYNC_STAGES(SYNC_STAGES)) u_gate_interlock (
        .clk(clk), .rst_n(rst_n), .estop_n(estop_n), .oc_trip(oc_trip),
        .ov_flag(ov_flag), .uv_flag(uv_flag), .stall_flag(stall_flag),
        .clr_req(clr_req), .gate_en(gate_en), .fault_code(fault_code),
        .fault_latched(fault_latched)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input logic [4:0] m);
        estop_n = ~m[0]; oc_trip = m[1]; ov_flag = m[2]; uv_flag = m[3]; stall_flag = m[4];
    endtask

    task automatic pulse_clear();
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
    endtask

    function automatic int prio_code(input logic [4:0] m);
        for (int i = 0; i < 5; i++) if (m[i]) return i + 1;
        return 0;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; drive(5'b0); clr_req = 1'b0;
        wait_neg(2);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state, disarmed
        chk("R1 gate", gate_en, 0);
        chk("R1 code", fault_code, 0);
        chk("R1 latched", fault_latched, 0);
        wait_neg(SETTLE);
        chk("R1 still disarmed", gate_en, 0);
        pulse_clear();
        chk("R1 armed after clear", gate_en, 1);

        // exhaustive sweep of fault combinations
        for (int m = 1; m < 32; m++) begin
            @(negedge clk);
            drive(5'(m));
            #1;
            if (m[0]) chk("R2 estop comb cut", gate_en, 0);
            if (m[1]) chk("R3 overcurrent comb cut", gate_en, 0);
            wait_neg(SETTLE);
            chk("R4 latched", fault_latched, 1);
            chk("R4 gate off", gate_en, 0);
            chk("R5 R6 code", fault_code, prio_code(5'(m)));
            pulse_clear();
            wait_neg(1);
            chk("R8 clear ignored latched", fault_latched, 1);
            chk("R8 clear ignored gate", gate_en, 0);
            drive(5'b0);
            wait_neg(SETTLE);
            chk("R4 stays latched", fault_latched, 1);
            chk("R4 gate stays off", gate_en, 0);
            pulse_clear();
            chk("R9 gate on", gate_en, 1);
            chk("R9 code cleared", fault_code, 0);
            chk("R9 unlatched", fault_latched, 0);
        end

        // R7: first fault kept, every ordered pair of distinct sources
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                if (a != b) begin
                    drive(5'(1 << a));
                    wait_neg(SETTLE);
                    drive(5'((1 << a) | (1 << b)));
                    wait_neg(SETTLE);
                    chk("R7 first fault kept", fault_code, a + 1);
                    drive(5'(1 << b));
                    wait_neg(SETTLE);
                    chk("R7 code after first removed", fault_code, a + 1);
                    drive(5'b0);
                    wait_neg(SETTLE);
                    pulse_clear();
                    chk("R9 rearmed", gate_en, 1);
                end
            end
        end

        // R10: fault while disarmed after reset
        do_reset();
        drive(5'b01000);
        wait_neg(SETTLE);
        chk("R10 latched from safe", fault_latched, 1);
        chk("R10 code from safe", fault_code, 4);
        drive(5'b0);
        wait_neg(SETTLE);
        pulse_clear();
        chk("R10 armed after recovery", gate_en, 1);

        // R2: brief estop dip cuts the gate without a clock edge
        @(negedge clk);
        #1 estop_n = 1'b0;
        #0.5 chk("R2 mid-cycle cut", gate_en, 0);
        finish_run();
    end
endmodule